// File: doc/BRIEF.md
# Sequential Radix-2 SRT Integer Divider

This block divides one unsigned integer by another over several clock cycles. It produces the quotient and the remainder. A pulse on `start` captures both operands. The block first left-aligns the divisor so that its top bit is set, and shifts the dividend by the same amount. It then produces one signed quotient digit per cycle. Each digit is +1, 0 or −1, and it is picked from only the three leading bits of the partial remainder. While the remainder stays small the step is a bare shift. A step that does add or subtract the aligned divisor never needs a full-width comparison.

The positive digits and the negative digits are collected in two separate vectors. After the last digit, one closing cycle does three things: it subtracts the two vectors to form the binary quotient, repairs a negative remainder, and shifts the remainder back by the alignment amount. A zero divisor skips all iteration. It sets a flag, returns an all-ones quotient and passes the dividend back as the remainder.

Top module: `srt_divider`

## Requirements
- R1: During and after reset, `busy`, `done`, `div_by_zero`, `quotient` and `remainder` are all zero.
- R2: A `start` seen while `busy` is low is accepted. `busy` is then high from the next cycle until the result cycle, and it is low in the cycle where `done` is high.
- R3: For a non-zero divisor, `done` is high for exactly one cycle, WIDTH+2 clock edges after the edge that accepted `start`.
- R4: For a non-zero divisor, `quotient` equals floor(dividend / divisor) and `remainder` equals dividend mod divisor, so `remainder` is less than the divisor. This includes a quotient digit sequence that ends on a negative partial remainder, which must be repaired (for example 0x00AA / 0x0002 gives 0x0055 remainder 0).
- R5: A zero divisor gives `done` one clock edge after the accepting edge, with `div_by_zero` = 1, `quotient` all ones and `remainder` equal to the dividend.
- R6: A `start` pulse while `busy` is high is ignored: the running division returns its own result at its own time, and no extra `done` follows.
- R7: `quotient`, `remainder` and `div_by_zero` change only in a cycle where `done` is high, and hold their values between results regardless of the operand inputs.
- R8: Divisors needing no alignment (top bit set) and divisors needing the largest alignment (value 1) give correct results, as do a dividend of zero and a dividend smaller than the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division with the present operands |
| dividend | input | WIDTH | Unsigned dividend |
| divisor | input | WIDTH | Unsigned divisor |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse: results are new |
| div_by_zero | output | 1 | Last result came from a zero divisor |
| quotient | output | WIDTH | Unsigned quotient |
| remainder | output | WIDTH | Unsigned remainder |

## Verification
The bench builds two copies of the divider. The first has the default WIDTH of 16. It runs directed cases: alignment extremes, zero divisor, start while busy, output holding, and a seeded pseudo-random sweep. The second copy has WIDTH of 5, small enough to try every dividend and divisor pair (1024 divisions). Every alignment amount, every digit pattern and every case that ends on a negative remainder are therefore exercised exhaustively at that width.

// File: rtl/srt_div_pkg.sv
package srt_div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_NORM = 2'd1,
        ST_ITER = 2'd2,
        ST_FIX  = 2'd3
    } srt_state_e;
endpackage

// File: rtl/srt_lzc.sv
module srt_lzc #(
    parameter int WIDTH = 16,
    localparam int KW = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] value,
    output logic [KW-1:0]    count,
    output logic             is_zero
);
    always_comb begin
        count = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (value[i]) count = KW'(WIDTH - 1 - i);
        end
        is_zero = ~|value;
    end
endmodule

// File: rtl/srt_digit_sel.sv
module srt_digit_sel (
    input  logic [2:0] lead,
    output logic       dig_pos,
    output logic       dig_neg
);
    logic all_same;
    always_comb begin
        all_same = (lead == 3'b000) || (lead == 3'b111);
        dig_neg  = !all_same && lead[2];
        dig_pos  = !all_same && !lead[2];
    end
endmodule

// File: rtl/srt_step.sv
module srt_step #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH:0]   prem,
    input  logic             shift_in,
    input  logic [WIDTH-1:0] dnorm,
    input  logic             dig_pos,
    input  logic             dig_neg,
    output logic [WIDTH:0]   prem_next
);
    logic [WIDTH+1:0] doubled;
    logic [WIDTH+1:0] dext;
    logic [WIDTH+1:0] sum;
    always_comb begin
        doubled = {prem, shift_in};
        dext    = {2'b00, dnorm};
        if (dig_pos)      sum = doubled - dext;
        else if (dig_neg) sum = doubled + dext;
        else              sum = doubled;
        prem_next = sum[WIDTH:0];
    end
endmodule

// File: rtl/srt_divider.sv
module srt_divider
    import srt_div_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int KW = $clog2(WIDTH),
    localparam int CW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic             div_by_zero,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder
);
    typedef struct packed {
        srt_state_e       st;
        logic [CW-1:0]    cnt;
        logic [KW-1:0]    k;
        logic [WIDTH:0]   prem;
        logic [WIDTH-1:0] qsh;
        logic [WIDTH-1:0] dn;
        logic [WIDTH-1:0] qpos;
        logic [WIDTH-1:0] qneg;
        logic [WIDTH-1:0] quo;
        logic [WIDTH-1:0] rem;
        logic             dz;
        logic             done;
    } regs_t;

    regs_t r_q, r_d;

    logic [KW-1:0]    lz_count;
    logic             lz_zero;
    logic             sel_pos, sel_neg;
    logic [WIDTH:0]   step_next;

    srt_lzc #(.WIDTH(WIDTH)) u_lzc (
        .value   (r_q.dn),
        .count   (lz_count),
        .is_zero (lz_zero)
    );

    srt_digit_sel u_sel (
        .lead    (r_q.prem[WIDTH:WIDTH-2]),
        .dig_pos (sel_pos),
        .dig_neg (sel_neg)
    );

    srt_step #(.WIDTH(WIDTH)) u_step (
        .prem      (r_q.prem),
        .shift_in  (r_q.qsh[WIDTH-1]),
        .dnorm     (r_q.dn),
        .dig_pos   (sel_pos),
        .dig_neg   (sel_neg),
        .prem_next (step_next)
    );

    logic [2*WIDTH-1:0] wide_sh;
    logic [WIDTH:0]     prem_fix;
    logic               rem_neg;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        wide_sh  = {{WIDTH{1'b0}}, r_q.qsh} << r_q.k;
        rem_neg  = r_q.prem[WIDTH];
        prem_fix = rem_neg ? (r_q.prem + {1'b0, r_q.dn}) : r_q.prem;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.qsh  = dividend;
                    r_d.dn   = divisor;
                    r_d.prem = '0;
                    r_d.st   = ST_NORM;
                end
            end
            ST_NORM: begin
                if (lz_zero) begin
                    r_d.quo  = '1;
                    r_d.rem  = r_q.qsh;
                    r_d.dz   = 1'b1;
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else begin
                    r_d.k    = lz_count;
                    wide_sh  = {{WIDTH{1'b0}}, r_q.qsh} << lz_count;
                    r_d.prem = {1'b0, wide_sh[2*WIDTH-1:WIDTH]};
                    r_d.qsh  = wide_sh[WIDTH-1:0];
                    r_d.dn   = r_q.dn << lz_count;
                    r_d.qpos = '0;
                    r_d.qneg = '0;
                    r_d.cnt  = '0;
                    r_d.st   = ST_ITER;
                end
            end
            ST_ITER: begin
                r_d.prem = step_next;
                r_d.qsh  = r_q.qsh << 1;
                r_d.qpos = {r_q.qpos[WIDTH-2:0], sel_pos};
                r_d.qneg = {r_q.qneg[WIDTH-2:0], sel_neg};
                r_d.cnt  = r_q.cnt + 1'b1;
                if (r_q.cnt == CW'(WIDTH - 1)) r_d.st = ST_FIX;
            end
            ST_FIX: begin
                r_d.quo  = r_q.qpos - r_q.qneg - WIDTH'(rem_neg);
                r_d.rem  = prem_fix[WIDTH-1:0] >> r_q.k;
                r_d.dz   = 1'b0;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy        = (r_q.st != ST_IDLE);
    assign done        = r_q.done;
    assign div_by_zero = r_q.dz;
    assign quotient    = r_q.quo;
    assign remainder   = r_q.rem;
endmodule

// File: rtl/srt_divider_chk.sv
module srt_divider_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [WIDTH-1:0] dividend,
    input logic [WIDTH-1:0] divisor,
    input logic             busy,
    input logic             done,
    input logic             div_by_zero,
    input logic [WIDTH-1:0] quotient,
    input logic [WIDTH-1:0] remainder
);
    localparam int LW = $clog2(WIDTH + 4) + 1;

    logic             accept;
    logic [LW-1:0]    lat_q;
    logic [WIDTH-1:0] op_a_q, op_b_q;
    logic [2*WIDTH-1:0] recomb;

    assign accept = start && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q  <= '0;
            op_a_q <= '0;
            op_b_q <= '0;
        end else if (accept) begin
            lat_q  <= '0;
            op_a_q <= dividend;
            op_b_q <= divisor;
        end else if (busy) begin
            lat_q  <= lat_q + 1'b1;
        end
    end

    always_comb begin
        recomb = (2*WIDTH)'(quotient) * (2*WIDTH)'(op_b_q) + (2*WIDTH)'(remainder);
    end

    // R2: accepted start makes the block busy next cycle
    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    // R2: result cycle is not a busy cycle
    a_r2_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    // R3: single-cycle result pulse
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3: fixed latency for non-zero divisor
    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_by_zero) |-> (lat_q == LW'(WIDTH + 2)));
    // R4: quotient and remainder recombine to the dividend
    a_r4_recombine: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_by_zero) |-> (recomb == (2*WIDTH)'(op_a_q)));
    // R4: remainder below divisor
    a_r4_rem_small: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_by_zero) |-> (remainder < op_b_q));
    // R5: zero divisor result pattern
    a_r5_zero_div: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_by_zero) |-> (op_b_q == '0 && quotient == '1
                                   && remainder == op_a_q && lat_q == LW'(1)));
    // R7: outputs move only with done
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(quotient) || !$stable(remainder) || !$stable(div_by_zero)) |-> done);
endmodule

bind srt_divider srt_divider_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .dividend    (dividend),
    .divisor     (divisor),
    .busy        (busy),
    .done        (done),
    .div_by_zero (div_by_zero),
    .quotient    (quotient),
    .remainder   (remainder)
);

// File: tb/srt_divider_tb.sv
`timescale 1ns/1ps
module srt_divider_tb;
    localparam int W  = 16;
    localparam int WS = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          start = 1'b0;
    logic [W-1:0]  dividend = '0, divisor = '0;
    logic          busy, done, div_by_zero;
    logic [W-1:0]  quotient, remainder;

    logic          s_start = 1'b0;
    logic [WS-1:0] s_dividend = '0, s_divisor = '0;
    logic          s_busy, s_done, s_dz;
    logic [WS-1:0] s_quotient, s_remainder;

    int n_chk = 0;
    int n_fail = 0;

    srt_divider #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .busy(busy), .done(done), .div_by_zero(div_by_zero),
        .quotient(quotient), .remainder(remainder));

    srt_divider #(.WIDTH(WS)) u_dut_small (
        .clk(clk), .rst_n(rst_n), .start(s_start), .dividend(s_dividend),
        .divisor(s_divisor), .busy(s_busy), .done(s_done), .div_by_zero(s_dz),
        .quotient(s_quotient), .remainder(s_remainder));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        summary();
        $finish;
    end

    task automatic op16(input logic [W-1:0] a, input logic [W-1:0] b,
                        output logic [W-1:0] qo, output logic [W-1:0] ro,
                        output logic dzo, output int lat, output logic busy0);
        @(negedge clk);
        dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        busy0 = busy;
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        qo = quotient; ro = remainder; dzo = div_by_zero;
    endtask

    task automatic div_check16(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
        logic [W-1:0] q, r; logic dz, b0; int lat;
        op16(a, b, q, r, dz, lat, b0);
        chk(q == a / b, {req, " R4 quotient"}, q, a / b);
        chk(r == a % b, {req, " R4 remainder"}, r, a % b);
        chk(lat == W + 2 && !dz, {req, " R3 latency"}, lat, W + 2);
        chk(b0 == 1'b1 && busy == 1'b0, {req, " R2 busy"}, {b0, busy}, 2'b10);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !div_by_zero && quotient == 0 && remainder == 0,
            "R1 reset state", {busy, done, div_by_zero, quotient, remainder}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && quotient == 0 && remainder == 0,
            "R1 after reset", {busy, done, quotient, remainder}, 0);
    endtask

    task automatic t_basic();
        div_check16(16'h00AA, 16'h0002, "basic 0xAA/2");
        div_check16(16'd1000, 16'd7, "basic 1000/7");
        div_check16(16'd65535, 16'd255, "basic max/255");
        div_check16(16'd12345, 16'd123, "basic 12345/123");
        div_check16(16'd40000, 16'd3, "basic 40000/3");
    endtask

    task automatic t_norm_extremes();
        div_check16(16'd54321, 16'd1, "R8 divisor one");
        div_check16(16'hFFFF, 16'h8000, "R8 divisor top bit");
        div_check16(16'hFFFF, 16'hFFFF, "R8 equal max");
        div_check16(16'd0, 16'd9, "R8 zero dividend");
        div_check16(16'd5, 16'd300, "R8 small dividend");
        div_check16(16'h7FFF, 16'h8001, "R8 just below");
    endtask

    task automatic t_div_zero();
        logic [W-1:0] q, r; logic dz, b0; int lat;
        op16(16'h1234, 16'h0000, q, r, dz, lat, b0);
        chk(dz == 1'b1, "R5 flag", dz, 1);
        chk(q == 16'hFFFF, "R5 quotient", q, 16'hFFFF);
        chk(r == 16'h1234, "R5 remainder", r, 16'h1234);
        chk(lat == 1, "R5 latency", lat, 1);
        div_check16(16'd100, 16'd10, "R5 flag clears");
        chk(div_by_zero == 1'b0, "R5 flag cleared", div_by_zero, 0);
    endtask

    task automatic t_busy_start();
        int lat; int extra;
        @(negedge clk);
        dividend = 16'd1000; divisor = 16'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0; lat = 0;
        repeat (3) begin @(negedge clk); lat++; end
        dividend = 16'd5; divisor = 16'd1; start = 1'b1;
        @(negedge clk); lat++;
        start = 1'b0;
        while (!done && lat < 200) begin @(negedge clk); lat++; end
        chk(quotient == 16'd142 && remainder == 16'd6, "R6 result kept",
            {quotient, remainder}, {16'd142, 16'd6});
        chk(lat == W + 2, "R6 latency kept", lat, W + 2);
        extra = 0;
        repeat (25) begin @(negedge clk); if (done) extra++; end
        chk(extra == 0 && !busy, "R6 no extra done", extra, 0);
    endtask

    task automatic t_hold();
        logic [W-1:0] q0, r0; int bad;
        div_check16(16'd999, 16'd10, "R7 setup");
        q0 = quotient; r0 = remainder; bad = 0;
        repeat (6) begin
            @(negedge clk);
            dividend = dividend + 16'd77; divisor = divisor ^ 16'h0F0F;
            if (quotient != q0 || remainder != r0 || done) bad++;
        end
        chk(bad == 0, "R7 outputs hold", bad, 0);
    endtask

    task automatic t_random16();
        logic [31:0] seed = 32'h1ACE_5EED;
        logic [W-1:0] a, b;
        for (int i = 0; i < 150; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            a = seed[31:16];
            seed = seed * 32'd1664525 + 32'd1013904223;
            b = seed[31:16] >> seed[3:0];
            if (b == 0) b = 16'd3;
            div_check16(a, b, "R4 random");
        end
    endtask

    task automatic t_exhaustive_small();
        int lat;
        int bad_q = 0, bad_r = 0, bad_l = 0;
        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 32; b++) begin
                @(negedge clk);
                s_dividend = WS'(a); s_divisor = WS'(b); s_start = 1'b1;
                @(negedge clk);
                s_start = 1'b0; lat = 0;
                while (!s_done && lat < 100) begin @(negedge clk); lat++; end
                if (b == 0) begin
                    if (!s_dz || s_quotient != 5'h1F || s_remainder != WS'(a)) bad_q++;
                    if (lat != 1) bad_l++;
                end else begin
                    if (s_dz || s_quotient != WS'(a / b)) bad_q++;
                    if (s_remainder != WS'(a % b)) bad_r++;
                    if (lat != WS + 2) bad_l++;
                end
            end
        end
        chk(bad_q == 0, "R4 R5 R8 small quotient sweep", bad_q, 0);
        chk(bad_r == 0, "R4 R8 small remainder sweep", bad_r, 0);
        chk(bad_l == 0, "R3 small latency sweep", bad_l, 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_norm_extremes();
        t_div_zero();
        t_busy_start();
        t_hold();
        t_random16();
        t_exhaustive_small();
        summary();
        $finish;
    end
endmodule